// File: doc/BRIEF.md
# DMA Transfer Cycle Sequencer

This block is the cycle-level state machine of a DMA controller. It runs from the system clock and walks through one idle state and a set of active states, each lasting exactly one clock. From the current state it drives the address-latch strobe, the channel acknowledge, the memory and I/O read and write strobes, and a one-cycle marker on the last state of every transfer. Channel arbitration and address arithmetic live outside. A granted request arrives as `svc_req`, and the arbiter says through `run_more` whether another transfer should follow in the same run.

A normal transfer moves data between an I/O device and memory. It runs S0, then S1 (address strobe), S2 and S3 (strobes active) and S4 (last state). A memory-to-memory transfer uses its own eight-state path instead. A read half (S11 to S14) fetches from the source address and a write half (S21 to S24) stores to the destination.

Four command inputs shape the timing. They enable memory-to-memory, hold the controller off, compress the cycle, or widen the write strobe. An active-low end-of-process input stops a run after the transfer in progress finishes.

Top module: `dma_cycle_seq`

## Requirements
- R1: During and right after reset, `seq_state` is 0 (idle). All four strobes are high (inactive), and `adr_stb`, `dack`, `xfer_done` and `dst_phase` are low.
- R2: The sequencer leaves idle only when `svc_req` is high and `cmd_off` is low. It then enters S0 (code 1) on the next clock, and each state lasts one clock.
- R3: State codes are S0=1, S1=2, S2=3, S3=4, S4=5. A normal transfer runs S1, S2, S3, S4 after S0. `adr_stb` is high only in S1, S11 and S21. `dack` is high in S1 to S4. `xfer_done` is high in S4 and S24.
- R4: `xfer_kind` routes the strobes. With 01 (I/O to memory), `io_rd_n` is the read-side strobe and `mem_wr_n` the write-side. With 10 (memory to I/O), `mem_rd_n` is the read-side strobe and `io_wr_n` the write-side. With 00 and 11, no strobe asserts. The read-side strobe is low in S2, S3 and S4.
- R5: With `cmd_ext_wr` low, the write-side strobe is low in S3 and S4 only. With `cmd_ext_wr` high, it is also low in S2.
- R6: With `cmd_compress` high and `cmd_m2m` low, the second and later transfers of a run go from S2 straight to S4, while the first transfer still visits S3. The write-side strobe is then low from S2 whatever `cmd_ext_wr` is.
- R7: With `cmd_m2m` high, S0 is followed by S11 to S14 (codes 6 to 9) and then S21 to S24 (codes 10 to 13). `mem_rd_n` is low in S13 and S14. `mem_wr_n` is low in S23 and S24, and also in S22 when `cmd_ext_wr` is high. `dst_phase` is high in S21 to S24. `dack`, `io_rd_n` low and `io_wr_n` low never occur on this path, and `cmd_compress` has no effect.
- R8: In S4 or S24, if `run_more` is high and no end-of-process is pending, the next state is S1 or S11 respectively. Otherwise the sequencer returns to idle.
- R9: `eop_n` low on any clock edge in an active state ends the run after the last state of the current transfer. `eop_n` low while idle has no effect.
- R10: The command inputs and `xfer_kind` are captured when the sequencer leaves idle. Changes during a run take effect only at the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_m2m | input | 1 | Select the memory-to-memory path |
| cmd_off | input | 1 | Hold the controller disabled (stay idle) |
| cmd_compress | input | 1 | Compressed cycle timing |
| cmd_ext_wr | input | 1 | Extended (early) write strobe |
| xfer_kind | input | 2 | 00 verify, 01 I/O to memory, 10 memory to I/O, 11 none |
| svc_req | input | 1 | Granted channel request present |
| run_more | input | 1 | Another transfer follows in this run |
| eop_n | input | 1 | End of process, active low |
| seq_state | output | 4 | Current state code |
| adr_stb | output | 1 | Address latch strobe |
| dack | output | 1 | Channel acknowledge, active high |
| xfer_done | output | 1 | Last state of a transfer |
| dst_phase | output | 1 | Memory-to-memory write half |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |

## Verification
End-of-process and run continuation can land on the same last state of a transfer. There, `eop_n` falls while `run_more` is still high, or it fell earlier in the transfer. The bench drives both situations, in directed form and through random `eop_n` pulses across long runs. A per-cycle model that applies the R8 and R9 rules decides the outcome: the sequencer must return to idle rather than start another transfer. A second overlap is a command change on the same edge that starts a run, or in the middle of one. The model captures the command only at the start of a run.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int STATE_W = 4;
    localparam int KIND_W  = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 4'd0,
        ST_S0   = 4'd1,
        ST_S1   = 4'd2,
        ST_S2   = 4'd3,
        ST_S3   = 4'd4,
        ST_S4   = 4'd5,
        ST_MR1  = 4'd6,
        ST_MR2  = 4'd7,
        ST_MR3  = 4'd8,
        ST_MR4  = 4'd9,
        ST_MW1  = 4'd10,
        ST_MW2  = 4'd11,
        ST_MW3  = 4'd12,
        ST_MW4  = 4'd13
    } seq_state_e;

    localparam logic [KIND_W-1:0] KIND_IO2MEM = 2'b01;
    localparam logic [KIND_W-1:0] KIND_MEM2IO = 2'b10;

    // Run configuration, frozen while a run is in progress
    typedef struct packed {
        logic              m2m;
        logic              compress;
        logic              wr_early;
        logic [KIND_W-1:0] kind;
    } seq_cfg_t;

endpackage

// File: rtl/dma_seq_cfg.sv
module dma_seq_cfg
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              cmd_m2m,
    input  logic              cmd_compress,
    input  logic              cmd_ext_wr,
    input  logic [KIND_W-1:0] kind,
    output seq_cfg_t          cfg_q
);

    seq_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d.m2m      = cmd_m2m;
            // compression only applies to the single-bus path
            cfg_d.compress = cmd_compress & ~cmd_m2m;
            // compressed cycles always place the write strobe early
            cfg_d.wr_early = cmd_m2m ? cmd_ext_wr : (cmd_compress | cmd_ext_wr);
            cfg_d.kind     = kind;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       run_more,
    input  logic       eop_n,
    input  logic       m2m,
    input  logic       compress,
    output seq_state_e state,
    output logic       load
);

    typedef struct packed {
        seq_state_e state;
        logic       again;     // a transfer of this run has already completed
        logic       eop_seen;  // end of process pending
    } fsm_t;

    fsm_t q, d;
    logic eop_now;
    logic last;

    always_comb begin
        d       = q;
        load    = 1'b0;
        eop_now = ~eop_n & (q.state != ST_IDLE);
        last    = q.eop_seen | eop_now | ~run_more;
        if (eop_now) d.eop_seen = 1'b1;

        unique case (q.state)
            ST_IDLE: begin
                if (go) begin
                    d.state    = ST_S0;
                    d.again    = 1'b0;
                    d.eop_seen = 1'b0;
                    load       = 1'b1;
                end
            end
            ST_S0:  d.state = m2m ? ST_MR1 : ST_S1;
            ST_S1:  d.state = ST_S2;
            ST_S2:  d.state = (compress & q.again) ? ST_S4 : ST_S3;
            ST_S3:  d.state = ST_S4;
            ST_MR1: d.state = ST_MR2;
            ST_MR2: d.state = ST_MR3;
            ST_MR3: d.state = ST_MR4;
            ST_MR4: d.state = ST_MW1;
            ST_MW1: d.state = ST_MW2;
            ST_MW2: d.state = ST_MW3;
            ST_MW3: d.state = ST_MW4;
            ST_S4, ST_MW4: begin
                if (last) begin
                    d.state    = ST_IDLE;
                    d.again    = 1'b0;
                    d.eop_seen = 1'b0;
                end else begin
                    d.state = (q.state == ST_S4) ? ST_S1 : ST_MR1;
                    d.again = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_IDLE, again: 1'b0, eop_seen: 1'b0};
        else        q <= d;
    end

    assign state = q.state;

endmodule

// File: rtl/dma_seq_strobe.sv
module dma_seq_strobe
    import dma_seq_pkg::*;
(
    input  seq_state_e state,
    input  seq_cfg_t   cfg,
    output logic       adr_stb,
    output logic       dack,
    output logic       xfer_done,
    output logic       dst_phase,
    output logic       mem_rd_n,
    output logic       mem_wr_n,
    output logic       io_rd_n,
    output logic       io_wr_n
);

    logic rd_win, wr_win, m_rd, m_wr, to_mem, to_io;

    always_comb begin
        to_mem = (cfg.kind == KIND_IO2MEM);
        to_io  = (cfg.kind == KIND_MEM2IO);
        rd_win = state inside {ST_S2, ST_S3, ST_S4};
        wr_win = (state inside {ST_S3, ST_S4}) | (cfg.wr_early & (state == ST_S2));
        m_rd   = state inside {ST_MR3, ST_MR4};
        m_wr   = (state inside {ST_MW3, ST_MW4}) | (cfg.wr_early & (state == ST_MW2));

        adr_stb   = state inside {ST_S1, ST_MR1, ST_MW1};
        dack      = state inside {ST_S1, ST_S2, ST_S3, ST_S4};
        xfer_done = state inside {ST_S4, ST_MW4};
        dst_phase = state inside {ST_MW1, ST_MW2, ST_MW3, ST_MW4};

        mem_rd_n = ~(m_rd | (rd_win & to_io));
        mem_wr_n = ~(m_wr | (wr_win & to_mem));
        io_rd_n  = ~(rd_win & to_mem);
        io_wr_n  = ~(wr_win & to_io);
    end

endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_m2m,
    input  logic              cmd_off,
    input  logic              cmd_compress,
    input  logic              cmd_ext_wr,
    input  logic [KIND_W-1:0] xfer_kind,
    input  logic              svc_req,
    input  logic              run_more,
    input  logic              eop_n,
    output logic [STATE_W-1:0] seq_state,
    output logic              adr_stb,
    output logic              dack,
    output logic              xfer_done,
    output logic              dst_phase,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n
);

    seq_cfg_t   cfg_q;
    seq_state_e state;
    logic       load;
    logic       go;

    assign go = svc_req & ~cmd_off;

    dma_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .run_more (run_more),
        .eop_n    (eop_n),
        .m2m      (cfg_q.m2m),
        .compress (cfg_q.compress),
        .state    (state),
        .load     (load)
    );

    dma_seq_cfg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .cmd_m2m      (cmd_m2m),
        .cmd_compress (cmd_compress),
        .cmd_ext_wr   (cmd_ext_wr),
        .kind         (xfer_kind),
        .cfg_q        (cfg_q)
    );

    dma_seq_strobe u_strobe (
        .state     (state),
        .cfg       (cfg_q),
        .adr_stb   (adr_stb),
        .dack      (dack),
        .xfer_done (xfer_done),
        .dst_phase (dst_phase),
        .mem_rd_n  (mem_rd_n),
        .mem_wr_n  (mem_wr_n),
        .io_rd_n   (io_rd_n),
        .io_wr_n   (io_wr_n)
    );

    assign seq_state = state;

endmodule

// File: rtl/dma_cycle_seq_chk.sv
module dma_cycle_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_off,
    input logic       svc_req,
    input logic       run_more,
    input logic       eop_n,
    input logic [3:0] seq_state,
    input logic       adr_stb,
    input logic       dack,
    input logic       xfer_done,
    input logic       dst_phase,
    input logic       mem_rd_n,
    input logic       io_rd_n,
    input logic       io_wr_n
);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 4'd0 && (!svc_req || cmd_off)) |=> seq_state == 4'd0);

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 4'd0 && svc_req && !cmd_off) |=> seq_state == 4'd1);

    assert_stb_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adr_stb |=> !adr_stb);

    assert_s0_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state == 4'd1 |=> (seq_state == 4'd2 || seq_state == 4'd6));

    assert_one_reader_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~mem_rd_n, ~io_rd_n}) <= 1);

    assert_m2m_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state >= 4'd6 |-> (!dack && io_rd_n && io_wr_n));

    assert_dst_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dst_phase |-> mem_rd_n);

    assert_run_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !run_more) |=> seq_state == 4'd0);

    assert_eop_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !eop_n) |=> seq_state == 4'd0);

endmodule

bind dma_cycle_seq dma_cycle_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_off   (cmd_off),
    .svc_req   (svc_req),
    .run_more  (run_more),
    .eop_n     (eop_n),
    .seq_state (seq_state),
    .adr_stb   (adr_stb),
    .dack      (dack),
    .xfer_done (xfer_done),
    .dst_phase (dst_phase),
    .mem_rd_n  (mem_rd_n),
    .io_rd_n   (io_rd_n),
    .io_wr_n   (io_wr_n)
);

// File: tb/dma_cycle_seq_tb.sv
module dma_cycle_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_m2m = 1'b0, cmd_off = 1'b0, cmd_compress = 1'b0, cmd_ext_wr = 1'b0;
    logic [1:0] xfer_kind = 2'b00;
    logic       svc_req = 1'b0, run_more = 1'b0, eop_n = 1'b1;
    logic [3:0] seq_state;
    logic       adr_stb, dack, xfer_done, dst_phase;
    logic       mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;

    always #10 clk = ~clk;

    dma_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_m2m(cmd_m2m), .cmd_off(cmd_off),
        .cmd_compress(cmd_compress), .cmd_ext_wr(cmd_ext_wr), .xfer_kind(xfer_kind),
        .svc_req(svc_req), .run_more(run_more), .eop_n(eop_n), .seq_state(seq_state),
        .adr_stb(adr_stb), .dack(dack), .xfer_done(xfer_done), .dst_phase(dst_phase),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model state
    int   m_st = 0;
    bit   m_again = 0, m_eop = 0, m_m2m = 0, m_cmp = 0, m_ext = 0;
    int   m_kind = 0;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // expected outputs for model state, all requirement rules
    task automatic compare_all();
        bit early, rdw, wrw, mrd, mwr, tomem, toio;
        early = m_m2m ? m_ext : (m_cmp | m_ext);
        rdw   = (m_st >= 3 && m_st <= 5);
        wrw   = (m_st == 4 || m_st == 5) || (early && m_st == 3);
        mrd   = (m_st == 8 || m_st == 9);
        mwr   = (m_st == 12 || m_st == 13) || (m_ext && m_st == 11);
        tomem = (m_kind == 1);
        toio  = (m_kind == 2);
        check("R2 R3 R6 R7 R8 R9 R10 state", int'(seq_state), m_st);
        check("R3 adr_stb", int'(adr_stb), int'(m_st == 2 || m_st == 6 || m_st == 10));
        check("R3 dack", int'(dack), int'(m_st >= 2 && m_st <= 5));
        check("R3 xfer_done", int'(xfer_done), int'(m_st == 5 || m_st == 13));
        check("R7 dst_phase", int'(dst_phase), int'(m_st >= 10 && m_st <= 13));
        check("R4 R7 mem_rd_n", int'(mem_rd_n), int'(!(mrd || (rdw && toio))));
        check("R4 R5 R6 R7 mem_wr_n", int'(mem_wr_n), int'(!(mwr || (wrw && tomem))));
        check("R4 io_rd_n", int'(io_rd_n), int'(!(rdw && tomem)));
        check("R4 R5 R6 io_wr_n", int'(io_wr_n), int'(!(wrw && toio)));
    endtask

    task automatic step_model();
        bit eop_now, last;
        eop_now = !eop_n && m_st != 0;
        last    = m_eop || eop_now || !run_more;
        if (eop_now) m_eop = 1;
        case (m_st)
            0: if (svc_req && !cmd_off) begin
                   m_st = 1; m_again = 0; m_eop = 0;
                   m_m2m = cmd_m2m; m_cmp = cmd_compress && !cmd_m2m;
                   m_ext = cmd_ext_wr; m_kind = int'(xfer_kind);
               end
            1: m_st = m_m2m ? 6 : 2;
            3: m_st = (m_cmp && m_again) ? 5 : 4;
            5, 13: if (last) begin m_st = 0; m_again = 0; m_eop = 0; end
                   else begin m_st = (m_st == 5) ? 2 : 6; m_again = 1; end
            default: m_st = m_st + 1;
        endcase
    endtask

    // inputs set at a falling edge; compare now, advance model, wait a cycle
    task automatic tick();
        compare_all();
        step_model();
        @(negedge clk);
    endtask

    task automatic run_to(int s);
        for (int g = 0; g < 40 && int'(seq_state) != s; g++) tick();
    endtask

    task automatic set_cmd(bit m2m, bit off, bit cmp, bit ext, logic [1:0] kind);
        cmd_m2m = m2m; cmd_off = off; cmd_compress = cmp; cmd_ext_wr = ext; xfer_kind = kind;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        int seqc[12];
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1: outputs while reset held
        check("R1 state in reset", int'(seq_state), 0);
        check("R1 strobes in reset", int'({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}), 15);
        check("R1 pulses in reset", int'({adr_stb, dack, xfer_done, dst_phase}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        tick();

        // R2: controller off keeps idle
        set_cmd(0, 1, 0, 0, 2'b01);
        svc_req = 1;
        repeat (4) tick();
        check("R2 held idle while off", int'(seq_state), 0);
        svc_req = 0; cmd_off = 0;
        tick();

        // R6: compressed run, S3 skipped after the first transfer
        seqc = '{0, 1, 2, 3, 4, 5, 2, 3, 5, 2, 3, 5};
        set_cmd(0, 0, 1, 0, 2'b01);
        svc_req = 1; run_more = 1;
        for (int i = 0; i < 12; i++) begin
            check("R6 compressed sequence", int'(seq_state), seqc[i]);
            if (seqc[i] == 3) check("R6 early write in S2", int'(mem_wr_n), 0);
            if (i == 11) begin run_more = 0; svc_req = 0; end
            tick();
        end
        check("R8 idle after last transfer", int'(seq_state), 0);

        // R5 and R4: late write, memory to I/O
        set_cmd(0, 0, 0, 0, 2'b10);
        svc_req = 1; run_more = 0;
        run_to(3);
        svc_req = 0;
        check("R5 late write inactive in S2", int'(io_wr_n), 1);
        check("R4 memory read in S2", int'(mem_rd_n), 0);
        tick();
        check("R5 late write active in S3", int'(io_wr_n), 0);
        run_to(0);

        // R5: extended write
        set_cmd(0, 0, 0, 1, 2'b10);
        svc_req = 1;
        run_to(3);
        svc_req = 0;
        check("R5 extended write in S2", int'(io_wr_n), 0);
        run_to(0);

        // R7: memory to memory, compression ignored, extended write
        set_cmd(1, 0, 1, 1, 2'b01);
        svc_req = 1; run_more = 0;
        tick();
        svc_req = 0;
        for (int s = 1; s <= 13; s++) begin
            if (s == 2) s = 6;
            check("R7 m2m sequence", int'(seq_state), s);
            if (s == 11) check("R7 extended memory write in S22", int'(mem_wr_n), 0);
            if (s == 8)  check("R7 memory read in S13", int'(mem_rd_n), 0);
            tick();
        end
        check("R7 idle after S24", int'(seq_state), 0);

        // R9: end of process in S0 ends the run despite run_more
        set_cmd(0, 0, 0, 0, 2'b01);
        svc_req = 1; run_more = 1;
        tick();
        svc_req = 0; eop_n = 0;
        tick();
        eop_n = 1;
        run_to(5);
        tick();
        check("R9 eop stops run", int'(seq_state), 0);

        // R9: end of process in idle ignored
        eop_n = 0;
        repeat (2) tick();
        eop_n = 1; svc_req = 1; run_more = 1;
        tick();
        svc_req = 0;
        run_to(5);
        tick();
        check("R9 idle eop ignored, run continues", int'(seq_state), 2);
        run_more = 0;
        run_to(0);

        // R10: command change mid-run has no effect
        set_cmd(0, 0, 0, 0, 2'b01);
        svc_req = 1;
        tick();
        svc_req = 0;
        set_cmd(0, 0, 0, 1, 2'b10);
        run_to(3);
        check("R10 kind frozen: io read", int'(io_rd_n), 0);
        check("R10 kind frozen: no memory read", int'(mem_rd_n), 1);
        check("R10 ext frozen: late write", int'(mem_wr_n), 1);
        run_to(0);

        // constrained random
        for (int c = 0; c < 6000; c++) begin
            if (m_st == 0 || $urandom_range(0, 19) == 0) begin
                cmd_m2m      = ($urandom_range(0, 3) == 0);
                cmd_off      = ($urandom_range(0, 7) == 0);
                cmd_compress = ($urandom_range(0, 1) == 1);
                cmd_ext_wr   = ($urandom_range(0, 1) == 1);
                xfer_kind    = 2'($urandom_range(0, 3));
            end
            svc_req  = ($urandom_range(0, 1) == 1);
            run_more = ($urandom_range(0, 3) != 0);
            eop_n    = ($urandom_range(0, 11) != 0);
            tick();
        end
        summary();
    end

endmodule